// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions

This block is the tag side of a set-associative cache. It holds 2^SET_BITS sets of ASSOC ways, and each way stores a line tag and a two-bit access permission. A controller sends it one command per cycle. The commands cover access checks for loads, instruction fetches and stores, presence and availability tests, allocation, release, permission updates and victim selection. A hit depends on both the line's permission and the request type. Per-set age counters implement true least-recently-used replacement.

The request carries a line address. Its low SET_BITS bits select the set, and the remaining upper bits form the tag. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its result appears on the response outputs for exactly one cycle, one cycle later. A command that is not legal in the current state only raises the error flag and changes no state.

Top module: `tagdir_top`

## Requirements
- R1: After reset every way is empty (permission 2'b00) with tag zero. In every set the age order starts with way 0 as most recent and way ASSOC-1 as least recent. `req_ready` is low while `rst_n` is low and goes high on the second rising clock edge after `rst_n` rises.
- R2: `rsp_valid` is high in the cycle after each accepted request and is low otherwise.
- R3: A normal lookup matches a way only if the tags are equal and the way's permission is not empty (2'b00). The presence test (`req_op`=1) returns `rsp_hit`=1 and the lowest matching way, or 0/0 when nothing matches.
- R4: The access check (`req_op`=0) uses the permission codes 2'b01 invalid, 2'b10 read-only and 2'b11 read-write, and the `req_kind` codes 0 load, 1 fetch, 2 store and 3 treated as store. It hits on a read-write line, and on a read-only line for a load or a fetch. It returns the matched way, or way 0 when no tag matches.
- R5: Any access check that finds a tag match makes that way most recent, even when the permission refuses the access. Ways that were more recent move one step older. The probe victim is the least recent way.
- R6: The availability test (`req_op`=2) reports hit when any way of the set has an equal tag regardless of permission, or when any way is empty.
- R7: Allocate (`req_op`=3) writes the tag into the lowest-numbered empty way, sets that way to invalid (2'b01), makes it most recent and returns its index.
- R8: Deallocate (`req_op`=4) sets the matching way to empty. Change permission (`req_op`=5) writes `req_perm` into the matching way. Both return the way index and leave the age order unchanged.
- R9: Victim probe (`req_op`=6) on a full set returns the victim way index and, on `rsp_line`, that way's stored tag concatenated with the set index. `rsp_line` is zero for every other command.
- R10: The following raise `rsp_err` with hit, way and line all zero, and change no tag, permission or age: allocate with the tag already present or the set full; deallocate or change permission with no match; probe when an empty way exists; and `req_op`=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 3 | Command code |
| req_kind | input | 2 | Access type for access checks |
| req_line | input | LINE_W | Line address (tag above set index) |
| req_perm | input | 2 | New permission for change permission |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Hit or test result |
| rsp_err | output | 1 | Illegal command |
| rsp_way | output | log2(ASSOC) | Way index of the result |
| rsp_line | output | LINE_W | Victim line address on probe |

## Verification
A corrupted tag or permission in a way surfaces at the ports on the next command that uses that set. A presence test, an access or an availability test gives the wrong hit or way, and the result appears one cycle after the request. A wrong age order stays hidden until that set is full and is probed, at which point `rsp_line` and `rsp_way` name the wrong victim. The bench therefore fills sets often, so that age faults are exposed within a few dozen requests. A lost state write also shows as an unexpected error flag on a later allocate or deallocate.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_INV  = 2'b01,
    PERM_RO   = 2'b10,
    PERM_RW   = 2'b11
  } perm_e;

  typedef enum logic [2:0] {
    OP_ACCESS  = 3'd0,
    OP_PRESENT = 3'd1,
    OP_AVAIL   = 3'd2,
    OP_ALLOC   = 3'd3,
    OP_FREE    = 3'd4,
    OP_SETPERM = 3'd5,
    OP_PROBE   = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_STORE = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;
endpackage

// File: rtl/tagdir_array.sv
module tagdir_array #(
  parameter int SET_BITS = 2,
  parameter int ASSOC    = 4,
  parameter int TAG_W    = 10
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [SET_BITS-1:0]              set_i,
  output logic [ASSOC-1:0][TAG_W-1:0]      tags_o,
  output logic [ASSOC-1:0][1:0]            perms_o,
  input  logic                             wr_en,
  input  logic                             wr_tag_en,
  input  logic [$clog2(ASSOC)-1:0]         wr_way,
  input  logic [TAG_W-1:0]                 wr_tag,
  input  logic [1:0]                       wr_perm
);
  localparam int NSETS = 1 << SET_BITS;

  logic [TAG_W-1:0] tag_q  [NSETS][ASSOC];
  logic [1:0]       perm_q [NSETS][ASSOC];

  always_comb begin
    for (int w = 0; w < ASSOC; w++) begin
      tags_o[w]  = tag_q[set_i][w];
      perms_o[w] = perm_q[set_i][w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) begin
        for (int w = 0; w < ASSOC; w++) begin
          tag_q[s][w]  <= '0;
          perm_q[s][w] <= 2'b00;
        end
      end
    end else if (wr_en) begin
      if (wr_tag_en) tag_q[set_i][wr_way] <= wr_tag;
      perm_q[set_i][wr_way] <= wr_perm;
    end
  end
endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
  parameter int SET_BITS = 2,
  parameter int ASSOC    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SET_BITS-1:0]      set_i,
  input  logic                     touch_en,
  input  logic [$clog2(ASSOC)-1:0] touch_way,
  output logic [$clog2(ASSOC)-1:0] victim_o
);
  localparam int NSETS = 1 << SET_BITS;
  localparam int WAY_W = $clog2(ASSOC);

  logic [WAY_W-1:0] age_q [NSETS][ASSOC];
  logic [ASSOC-1:0][WAY_W-1:0] row, row_nxt;

  always_comb begin
    for (int w = 0; w < ASSOC; w++) row[w] = age_q[set_i][w];
  end

  always_comb begin
    for (int w = 0; w < ASSOC; w++) begin
      if (WAY_W'(w) == touch_way)          row_nxt[w] = '0;
      else if (row[w] < row[touch_way])    row_nxt[w] = row[w] + WAY_W'(1);
      else                                 row_nxt[w] = row[w];
    end
  end

  always_comb begin
    victim_o = '0;
    for (int w = 1; w < ASSOC; w++) begin
      if (row[w] > row[victim_o]) victim_o = WAY_W'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) begin
        for (int w = 0; w < ASSOC; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else if (touch_en) begin
      for (int w = 0; w < ASSOC; w++) age_q[set_i][w] <= row_nxt[w];
    end
  end
endmodule

// File: rtl/tagdir_lookup.sv
module tagdir_lookup #(
  parameter int ASSOC = 4,
  parameter int TAG_W = 10
) (
  input  logic [ASSOC-1:0][TAG_W-1:0] tags_i,
  input  logic [ASSOC-1:0][1:0]       perms_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic                        hit_any,
  output logic [$clog2(ASSOC)-1:0]    hit_way,
  output logic                        raw_any,
  output logic                        free_any,
  output logic [$clog2(ASSOC)-1:0]    free_way
);
  import tagdir_pkg::*;
  localparam int WAY_W = $clog2(ASSOC);

  always_comb begin
    hit_any  = 1'b0;
    hit_way  = '0;
    raw_any  = 1'b0;
    free_any = 1'b0;
    free_way = '0;
    for (int w = ASSOC - 1; w >= 0; w--) begin
      if (tags_i[w] == tag_i) begin
        raw_any = 1'b1;
        if (perms_i[w] != PERM_NONE) begin
          hit_any = 1'b1;
          hit_way = WAY_W'(w);
        end
      end
      if (perms_i[w] == PERM_NONE) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/tagdir_top.sv
module tagdir_top #(
  parameter int SET_BITS = 2,
  parameter int ASSOC    = 4,
  parameter int LINE_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2:0]               req_op,
  input  logic [1:0]               req_kind,
  input  logic [LINE_W-1:0]        req_line,
  input  logic [1:0]               req_perm,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_err,
  output logic [$clog2(ASSOC)-1:0] rsp_way,
  output logic [LINE_W-1:0]        rsp_line
);
  import tagdir_pkg::*;
  localparam int TAG_W = LINE_W - SET_BITS;
  localparam int WAY_W = $clog2(ASSOC);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];
  assign req_ready = rst_sync_q[1];

  logic                      take;
  op_e                       op;
  logic [SET_BITS-1:0]       set_idx;
  logic [TAG_W-1:0]          tag;
  logic [ASSOC-1:0][TAG_W-1:0] tags;
  logic [ASSOC-1:0][1:0]     perms;
  logic                      hit_any, raw_any, free_any;
  logic [WAY_W-1:0]          hit_way, free_way, vic_way;
  logic                      wr_en, wr_tag_en, touch_en;
  logic [WAY_W-1:0]          wr_way, touch_way;
  logic [1:0]                wr_perm;
  logic                      hit_d, err_d;
  logic [WAY_W-1:0]          way_d;
  logic [LINE_W-1:0]         line_d;
  logic                      kind_read;

  assign take      = req_valid & req_ready;
  assign op        = op_e'(req_op);
  assign set_idx   = req_line[SET_BITS-1:0];
  assign tag       = req_line[LINE_W-1:SET_BITS];
  assign kind_read = (req_kind == KIND_LOAD) || (req_kind == KIND_FETCH);

  tagdir_array #(.SET_BITS(SET_BITS), .ASSOC(ASSOC), .TAG_W(TAG_W)) u_array (
    .clk(clk), .rst_n(rst_int_n), .set_i(set_idx), .tags_o(tags), .perms_o(perms),
    .wr_en(wr_en), .wr_tag_en(wr_tag_en), .wr_way(wr_way), .wr_tag(tag), .wr_perm(wr_perm)
  );

  tagdir_lookup #(.ASSOC(ASSOC), .TAG_W(TAG_W)) u_lookup (
    .tags_i(tags), .perms_i(perms), .tag_i(tag), .hit_any(hit_any), .hit_way(hit_way),
    .raw_any(raw_any), .free_any(free_any), .free_way(free_way)
  );

  tagdir_lru #(.SET_BITS(SET_BITS), .ASSOC(ASSOC)) u_lru (
    .clk(clk), .rst_n(rst_int_n), .set_i(set_idx), .touch_en(touch_en),
    .touch_way(touch_way), .victim_o(vic_way)
  );

  // command decode: state writes and response values
  always_comb begin
    wr_en     = 1'b0;
    wr_tag_en = 1'b0;
    wr_way    = '0;
    wr_perm   = PERM_NONE;
    touch_en  = 1'b0;
    touch_way = '0;
    hit_d     = 1'b0;
    err_d     = 1'b0;
    way_d     = '0;
    line_d    = '0;
    unique case (op)
      OP_ACCESS: begin
        if (hit_any) begin
          touch_en  = take;
          touch_way = hit_way;
          way_d     = hit_way;
          hit_d     = (perms[hit_way] == PERM_RW) ||
                      ((perms[hit_way] == PERM_RO) && kind_read);
        end
      end
      OP_PRESENT: begin
        hit_d = hit_any;
        if (hit_any) way_d = hit_way;
      end
      OP_AVAIL: hit_d = raw_any | free_any;
      OP_ALLOC: begin
        if (hit_any || !free_any) begin
          err_d = 1'b1;
        end else begin
          wr_en     = take;
          wr_tag_en = 1'b1;
          wr_way    = free_way;
          wr_perm   = PERM_INV;
          touch_en  = take;
          touch_way = free_way;
          way_d     = free_way;
        end
      end
      OP_FREE, OP_SETPERM: begin
        if (!hit_any) begin
          err_d = 1'b1;
        end else begin
          wr_en   = take;
          wr_way  = hit_way;
          wr_perm = (op == OP_FREE) ? PERM_NONE : req_perm;
          way_d   = hit_way;
        end
      end
      OP_PROBE: begin
        if (free_any) begin
          err_d = 1'b1;
        end else begin
          way_d  = vic_way;
          line_d = {tags[vic_way], set_idx};
        end
      end
      default: err_d = 1'b1;
    endcase
  end

  // response registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_way   <= '0;
      rsp_line  <= '0;
    end else begin
      rsp_valid <= take;
      if (take) begin
        rsp_hit  <= hit_d;
        rsp_err  <= err_d;
        rsp_way  <= way_d;
        rsp_line <= line_d;
      end
    end
  end
endmodule

// File: rtl/tagdir_chk.sv
module tagdir_chk #(
  parameter int ASSOC = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     take,
  input logic [2:0]               req_op,
  input logic [1:0]               req_kind,
  input logic                     hit_any,
  input logic                     free_any,
  input logic [1:0]               hit_perm,
  input logic                     wr_en,
  input logic                     wr_tag_en,
  input logic                     touch_en,
  input logic                     rsp_valid,
  input logic                     rsp_hit,
  input logic                     rsp_err
);
  import tagdir_pkg::*;

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(take));

  p_err_excludes_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> !rsp_hit);

  p_store_ro_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_op == OP_ACCESS && hit_any && hit_perm == PERM_RO &&
    req_kind != KIND_LOAD && req_kind != KIND_FETCH |=> rsp_valid && !rsp_hit);

  p_match_touches_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_op == OP_ACCESS && hit_any |-> touch_en);

  p_alloc_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_tag_en |-> free_any && !hit_any);

  p_probe_free_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_op == OP_PROBE && free_any |=> rsp_err);
endmodule

bind tagdir_top tagdir_chk #(.ASSOC(ASSOC)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .take(take), .req_op(req_op), .req_kind(req_kind),
  .hit_any(hit_any), .free_any(free_any), .hit_perm(perms[hit_way]),
  .wr_en(wr_en), .wr_tag_en(wr_tag_en), .touch_en(touch_en),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err)
);

// File: tb/sim_tagdir_top.sv
module sim_tagdir_top;
  localparam int CLK_PERIOD = 10;
  localparam int SET_BITS = 2;
  localparam int ASSOC    = 4;
  localparam int LINE_W   = 12;
  localparam int NSETS    = 1 << SET_BITS;
  localparam int WAY_W    = $clog2(ASSOC);

  logic clk, rst_n, req_valid, req_ready;
  logic [2:0] req_op;
  logic [1:0] req_kind, req_perm;
  logic [LINE_W-1:0] req_line;
  logic rsp_valid, rsp_hit, rsp_err;
  logic [WAY_W-1:0] rsp_way;
  logic [LINE_W-1:0] rsp_line;

  tagdir_top #(.SET_BITS(SET_BITS), .ASSOC(ASSOC), .LINE_W(LINE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_kind(req_kind), .req_line(req_line), .req_perm(req_perm),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
    .rsp_way(rsp_way), .rsp_line(rsp_line)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int m_tag  [NSETS][ASSOC];
  int m_perm [NSETS][ASSOC];
  int m_lru  [NSETS][$];   // front = most recent

  bit exp_v = 0, exp_hit, exp_err;
  int exp_way, exp_line;
  string exp_req = "R2";
  string force_req = "";

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check("R2", "rsp_valid", int'(rsp_valid), int'(exp_v));
    if (exp_v) begin
      check(exp_req, "hit", int'(rsp_hit), int'(exp_hit));
      check(exp_req, "err", int'(rsp_err), int'(exp_err));
      check(exp_req, "way", int'(rsp_way), exp_way);
      check(exp_req == "R9" ? "R5" : exp_req, "line", int'(rsp_line), exp_line);
    end
  endtask

  task automatic touch(input int s, input int w);
    for (int k = 0; k < m_lru[s].size(); k++) begin
      if (m_lru[s][k] == w) begin
        m_lru[s].delete(k);
        break;
      end
    end
    m_lru[s].push_front(w);
  endtask

  task automatic model(input int c, input int kd, input int ln, input int pm);
    int s, tg, mw, fw;
    bit raw;
    s  = ln % NSETS;
    tg = ln / NSETS;
    mw = -1; fw = -1; raw = 0;
    for (int w = ASSOC - 1; w >= 0; w--) begin
      if (m_tag[s][w] == tg) raw = 1;
      if (m_tag[s][w] == tg && m_perm[s][w] != 0) mw = w;
      if (m_perm[s][w] == 0) fw = w;
    end
    exp_v = 1; exp_hit = 0; exp_err = 0; exp_way = 0; exp_line = 0;
    case (c)
      0: begin
        exp_req = "R4";
        if (mw >= 0) begin
          exp_way = mw;
          exp_hit = (m_perm[s][mw] == 3) || (m_perm[s][mw] == 2 && kd < 2);
          touch(s, mw);
        end
      end
      1: begin exp_req = "R3"; if (mw >= 0) begin exp_hit = 1; exp_way = mw; end end
      2: begin exp_req = "R6"; exp_hit = raw || (fw >= 0); end
      3: begin
        if (mw >= 0 || fw < 0) begin exp_req = "R10"; exp_err = 1; end
        else begin
          exp_req = "R7"; exp_way = fw;
          m_tag[s][fw] = tg; m_perm[s][fw] = 1; touch(s, fw);
        end
      end
      4, 5: begin
        if (mw < 0) begin exp_req = "R10"; exp_err = 1; end
        else begin
          exp_req = "R8"; exp_way = mw;
          m_perm[s][mw] = (c == 4) ? 0 : pm;
        end
      end
      6: begin
        if (fw >= 0) begin exp_req = "R10"; exp_err = 1; end
        else begin
          exp_req = "R9";
          exp_way = m_lru[s][$];
          exp_line = m_tag[s][exp_way] * NSETS + s;
        end
      end
      default: begin exp_req = "R10"; exp_err = 1; end
    endcase
    if (force_req != "") exp_req = force_req;
  endtask

  task automatic step(input bit v, input int c, input int kd, input int ln, input int pm);
    @(negedge clk);
    compare();
    req_valid = v;
    req_op    = 3'(c);
    req_kind  = 2'(kd);
    req_line  = LINE_W'(ln);
    req_perm  = 2'(pm);
    if (v && req_ready) model(c, kd, ln, pm);
    else exp_v = 0;
  endtask

  function automatic int mk(input int tg, input int s);
    return tg * NSETS + s;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog got 0 expected 1");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NSETS; s++) begin
      for (int w = 0; w < ASSOC; w++) begin
        m_tag[s][w] = 0; m_perm[s][w] = 0; m_lru[s].push_back(w);
      end
    end
    rst_n = 0; req_valid = 0; req_op = 0; req_kind = 0; req_line = 0; req_perm = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "ready_in_reset", int'(req_ready), 0);
    check("R1", "valid_in_reset", int'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "ready_after_1", int'(req_ready), 0);
    @(negedge clk);
    check("R1", "ready_after_2", int'(req_ready), 1);

    // reset contents: nothing present, every set free
    force_req = "R1";
    for (int s = 0; s < NSETS; s++) begin
      step(1, 1, 0, mk(0, s), 0);
      step(1, 6, 0, mk(0, s), 0);
    end
    force_req = "";

    // fill set 1, then exercise permissions, ages and errors
    for (int t = 1; t <= ASSOC; t++) step(1, 3, 0, mk(t, 1), 0);
    step(1, 3, 0, mk(9, 1), 0);          // full set
    step(1, 3, 0, mk(2, 1), 0);          // already present
    step(1, 6, 0, mk(0, 1), 0);          // victim = first allocated
    step(1, 5, 0, mk(1, 1), 2);          // tag 1 read-only
    step(1, 0, 2, mk(1, 1), 0);          // store to read-only misses, still touched
    step(1, 0, 0, mk(1, 1), 0);          // load hits
    step(1, 0, 1, mk(2, 1), 0);          // fetch on invalid misses
    step(1, 5, 0, mk(3, 1), 3);
    step(1, 0, 2, mk(3, 1), 0);          // store on read-write hits
    step(1, 0, 3, mk(3, 1), 0);
    step(1, 6, 0, mk(0, 1), 0);
    step(1, 2, 0, mk(7, 1), 0);          // full, no tag: not available
    step(1, 4, 0, mk(4, 1), 0);
    step(1, 2, 0, mk(4, 1), 0);
    step(1, 4, 0, mk(4, 1), 0);          // already gone
    step(1, 5, 0, mk(8, 1), 1);          // absent
    step(1, 7, 0, mk(1, 1), 0);          // reserved code
    step(0, 3, 0, mk(5, 1), 0);          // idle cycle ignored
    step(1, 1, 0, mk(4, 1), 0);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 85, (r < 30) ? 3 : int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
           mk(int'($urandom_range(0, 5)), int'($urandom_range(0, NSETS - 1))),
           int'($urandom_range(0, 3)));
    end
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule